// File: doc/BRIEF.md
# Hybrid Table-and-Iterative Modular Reducer

This block computes the remainder of a wide unsigned integer divided by a modulus `MOD`. The modulus is fixed when the block is elaborated. The input is cut into bit groups of width `GRP_W`, and the groups are handled by two paths that run side by side.

- **Iterative path.** The least significant `ITER_GRPS` groups form a plain integer. This path reduces it by restoring conditional subtraction, taking one shifted copy of the modulus per cycle.
- **Table path.** Each remaining, more significant group addresses its own constant table. Every table entry holds the residue of that group value times the group's positional weight. The looked-up residues are summed when the operand is accepted.

When the iterative path finishes, a fusion step adds the two partial residues. A correction step then subtracts the modulus, once per cycle, until the sum is below `MOD`.

Operands enter through a valid/ready handshake, and results leave through a second one. The block works on one operation at a time. It takes no new operand until the previous result has been taken.

Top module: `hyb_mod_reducer`

## Requirements
- R1: When `out_valid` is high, `out_data` equals `in_data mod MOD` for the operand accepted most recently. Any `IN_W`-bit value is a legal operand.
- R2: Whenever `out_valid` is high, `out_data` is strictly less than `MOD`.
- R3: `in_ready` is high only while no operation is in flight. It drops in the cycle after an operand is accepted and stays low until the result has been taken. While `out_valid` is high, `in_ready` is low.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R5: When the two partial residues are fused, the iterative path's remainder is strictly less than `MOD`.
- R6: The correction stage performs at most `TAB_GRPS` subtractions of `MOD`.
- R7: After reset, `in_ready` is 1 and `out_valid` is 0.
- R8: Let `SH_MAX = ITER_W - clog2(MOD)`. Counting clock edges from the accepting edge, `out_valid` rises between `SH_MAX+3` and `SH_MAX+3+TAB_GRPS` edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Block can accept an operand |
| in_data | input | IN_W | Operand to reduce |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | clog2(MOD) | Remainder in [0, MOD) |

## Verification
The bench builds the block with its default parameters: a 32-bit operand, 4-bit groups, four groups on the iterative path and a modulus of 251.

With these values the block has four tables of sixteen entries each, and the iterative path runs nine shift steps. Operands such as all-ones produce large table sums, so the correction stage runs for several cycles. Values at and around the modulus, zero, and operands with only high groups or only low groups set exercise each path on its own.

// File: rtl/hyb_mod_pkg.sv
package hyb_mod_pkg;

  typedef struct packed {
    logic load;
    logic iterStep;
    logic fuse;
    logic fixStep;
  } strobe_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ITER,
    PH_FUSE,
    PH_FIX,
    PH_DONE
  } phase_t;

endpackage

// File: rtl/hyb_mod_datapath.sv
module hyb_mod_datapath
  import hyb_mod_pkg::*;
#(
  parameter int IN_W      = 32,
  parameter int GRP_W     = 4,
  parameter int ITER_GRPS = 4,
  parameter int MOD       = 251,
  localparam int ITER_W   = GRP_W * ITER_GRPS,
  localparam int TAB_GRPS = (IN_W - ITER_W) / GRP_W,
  localparam int MW       = $clog2(MOD),
  localparam int SH_MAX   = ITER_W - MW,
  localparam int SHW      = $clog2(SH_MAX + 1),
  localparam int SW       = MW + $clog2(TAB_GRPS + 2),
  localparam int ENTRIES  = 1 << GRP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IN_W-1:0] inData,
  input  strobe_t         strb,
  input  logic [SHW-1:0]  shIdx,
  output logic            geMod,
  output logic [MW-1:0]   result
);

  localparam logic [ITER_W:0] MOD_X = (ITER_W + 1)'(MOD);
  localparam logic [SW-1:0]   MOD_S = SW'(MOD);

  // Residue of g * 2^(GRP_W*grpIdx) modulo MOD, evaluated at elaboration.
  function automatic logic [MW-1:0] tabEntry(input int grpIdx, input int g);
    longint unsigned pw;
    longint unsigned r;
    pw = 1;
    for (int j = 0; j < GRP_W * grpIdx; j++) pw = (pw * 2) % MOD;
    r = (longint'(g) * pw) % MOD;
    return r[MW-1:0];
  endfunction

  logic [MW-1:0] look [TAB_GRPS];

  for (genvar t = 0; t < TAB_GRPS; t++) begin : g_tab
    logic [MW-1:0] rom [ENTRIES];
    for (genvar v = 0; v < ENTRIES; v++) begin : g_ent
      assign rom[v] = tabEntry(ITER_GRPS + t, v);
    end
    assign look[t] = rom[inData[(ITER_GRPS + t) * GRP_W +: GRP_W]];
  end

  logic [SW-1:0] sumComb;
  always_comb begin
    sumComb = '0;
    for (int t = 0; t < TAB_GRPS; t++) sumComb = sumComb + SW'(look[t]);
  end

  logic [ITER_W-1:0] remReg;
  logic [SW-1:0]     tabReg;
  logic [SW-1:0]     accReg;
  logic [ITER_W:0]   modSh;
  logic              remGe;

  assign modSh = MOD_X << shIdx;
  assign remGe = {1'b0, remReg} >= modSh;

  always_ff @(posedge clk) begin
    if (strb.load) begin
      remReg <= inData[ITER_W-1:0];
      tabReg <= sumComb;
    end else if (strb.iterStep && remGe) begin
      remReg <= remReg - modSh[ITER_W-1:0];
    end
    if (strb.fuse)         accReg <= tabReg + SW'(remReg);
    else if (strb.fixStep) accReg <= accReg - MOD_S;
  end

  assign geMod  = accReg >= MOD_S;
  assign result = accReg[MW-1:0];

  // R5: the serial path has fully reduced its share before fusion
  p_iter_below_mod_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.fuse |-> ({1'b0, remReg} < MOD_X));

endmodule

// File: rtl/hyb_mod_ctrl.sv
module hyb_mod_ctrl
  import hyb_mod_pkg::*;
#(
  parameter int SH_MAX   = 8,
  parameter int TAB_GRPS = 4,
  localparam int SHW     = $clog2(SH_MAX + 1),
  localparam int FCW     = $clog2(TAB_GRPS + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inValid,
  output logic           inReady,
  output logic           outValid,
  input  logic           outReady,
  input  logic           geMod,
  output strobe_t        strb,
  output logic [SHW-1:0] shIdx
);

  phase_t         phase;
  logic [FCW-1:0] fixCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      shIdx  <= '0;
      fixCnt <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (inValid) begin
          phase <= PH_ITER;
          shIdx <= SHW'(SH_MAX);
        end
        PH_ITER: if (shIdx == '0) phase <= PH_FUSE;
                 else shIdx <= shIdx - 1'b1;
        PH_FUSE: begin
          phase  <= PH_FIX;
          fixCnt <= '0;
        end
        PH_FIX:  if (geMod) fixCnt <= fixCnt + 1'b1;
                 else phase <= PH_DONE;
        PH_DONE: if (outReady) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.load     = (phase == PH_IDLE) && inValid;
    strb.iterStep = (phase == PH_ITER);
    strb.fuse     = (phase == PH_FUSE);
    strb.fixStep  = (phase == PH_FIX) && geMod;
  end

  assign inReady  = (phase == PH_IDLE);
  assign outValid = (phase == PH_DONE);

  // R6: correction never needs more than one subtraction per table group
  p_fix_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FIX) |-> (fixCnt <= FCW'(TAB_GRPS)));

  // R3: an accepted operand closes the input until the result leaves
  p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> !inReady);

  // R4: a stalled result stays offered
  p_hold_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> outValid);

endmodule

// File: rtl/hyb_mod_reducer.sv
module hyb_mod_reducer
  import hyb_mod_pkg::*;
#(
  parameter int IN_W      = 32,
  parameter int GRP_W     = 4,
  parameter int ITER_GRPS = 4,
  parameter int MOD       = 251,
  localparam int ITER_W   = GRP_W * ITER_GRPS,
  localparam int TAB_GRPS = (IN_W - ITER_W) / GRP_W,
  localparam int MW       = $clog2(MOD),
  localparam int SH_MAX   = ITER_W - MW,
  localparam int SHW      = $clog2(SH_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IN_W-1:0] in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [MW-1:0]   out_data
);

  strobe_t        strb;
  logic [SHW-1:0] shIdx;
  logic           geMod;

  hyb_mod_ctrl #(.SH_MAX(SH_MAX), .TAB_GRPS(TAB_GRPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .inValid(in_valid), .inReady(in_ready),
    .outValid(out_valid), .outReady(out_ready),
    .geMod(geMod), .strb(strb), .shIdx(shIdx)
  );

  hyb_mod_datapath #(.IN_W(IN_W), .GRP_W(GRP_W), .ITER_GRPS(ITER_GRPS), .MOD(MOD)) u_dp (
    .clk(clk), .rst_n(rst_n), .inData(in_data),
    .strb(strb), .shIdx(shIdx), .geMod(geMod), .result(out_data)
  );

  // R2: every offered result is fully reduced
  p_out_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, out_data} < (MW + 1)'(MOD)));

  // R4: a stalled result keeps its value
  p_out_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));

  // R3: no operand is taken while a result waits
  p_no_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

endmodule

// File: tb/sim_hyb_mod_reducer.sv
module sim_hyb_mod_reducer;

  localparam int CLK_PER  = 10;
  localparam int MODV     = 251;
  localparam int TAB_G    = 4;
  localparam int SHMAX    = 8;
  localparam int NVEC     = 10;
  localparam logic [31:0] VEC [NVEC] = '{
    32'd0, 32'd250, 32'd251, 32'd252, 32'hFFFF_FFFF,
    32'h0000_FFFF, 32'hFFFF_0000, 32'h1234_5678, 32'h8000_0000, 32'd502
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;

  int nChk  = 0;
  int nFail = 0;
  int tick  = 0;

  always #(CLK_PER / 2) clk = ~clk;

  hyb_mod_reducer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runOne(input logic [31:0] x, input bit stall);
    int cyc;
    logic [7:0] held;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    cyc = 0;
    chk(in_ready == 1'b0, "R3 ready after accept", in_ready, 0);
    while (!out_valid && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc >= SHMAX + 3 && cyc <= SHMAX + 3 + TAB_G, "R8 latency", cyc, SHMAX + 3);
    chk(out_data == 8'(x % MODV), "R1 residue", out_data, x % MODV);
    chk(out_data < MODV, "R2 range", out_data, MODV - 1);
    if (stall) begin
      held = out_data;
      in_valid = 1'b1;
      in_data  = 32'h5A5A_5A5A;
      for (int k = 0; k < 3; k++) @(negedge clk);
      chk(out_valid == 1'b1, "R4 valid held", out_valid, 1);
      chk(out_data == held, "R4 data held", out_data, held);
      chk(in_ready == 1'b0, "R3 no accept while result waits", in_ready, 0);
      in_valid = 1'b0;
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R7 reset in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R7 reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NVEC; i++) runOne(VEC[i], 1'b0);
    for (int i = 0; i < 40; i++) runOne($urandom, 1'b0);
    runOne(32'hFFFF_FFFF, 1'b1);
    runOne(32'd250, 1'b1);
    // R6 and R5 are also guarded inside the design; this back-to-back pair
    // checks that the stalled operand offered during R4 was not captured.
    runOne(32'd7, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  always @(posedge clk) begin
    tick++;
    if (tick > 100000) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", tick, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

endmodule